// File: doc/BRIEF.md
# Flag-Based Branch and Loop Resolver

This block settles, one request per clock, whether a decoded short branch is taken and which instruction address comes next. A request carries a branch kind, a 4-bit condition code, the four arithmetic flags (sign, zero, overflow, carry), the address of the following instruction, an 8-bit signed displacement and the current value of the loop count register. The result is registered. It appears on the outputs one clock after the request is presented.

There are two families of branch kind. A conditional branch tests the flags through one of fourteen condition equations, which cover single-flag, unsigned-magnitude and signed-magnitude conditions. A counted loop always decrements the count and always asks for the decremented value to be written back. Whether the loop branches depends on that new count and, for two of the variants, on the zero flag. The taken target is the next-instruction address plus the sign-extended displacement. The arithmetic wraps modulo 2^32.

Top module: `brResolver`

## Requirements
- R1: Each request presented with `reqValid` high produces its result one clock later with `outValid` high. A clock with `reqValid` low produces `outValid`, `outTaken` and `outCountWr` all low in the following cycle.
- R2: Kind code 0 is the conditional branch. Its single-flag condition codes are 0 = O set, 1 = O clear, 2 = C set, 3 = C clear, 4 = Z set, 5 = Z clear, 8 = S set and 9 = S clear.
- R3: Condition code 6 is taken when (C OR Z) = 1. Condition code 7 is taken when (C OR Z) = 0.
- R4: Condition code 12 is taken when (S XOR O) = 1. Condition code 13 is taken when (S XOR O) = 0.
- R5: Condition code 14 is taken when Z OR (S XOR O) = 1. Condition code 15 is taken when that expression is 0.
- R6: Condition codes 10 and 11 are never taken, whatever the flags are.
- R7: A taken branch gives `outNextPtr` = `nextAddr` + sign-extended `offset`, modulo 2^32. For example, offset 0xF9 gives `nextAddr` - 7.
- R8: A request that is not taken gives `outNextPtr` = `nextAddr`.
- R9: Kind codes 1 (plain loop), 2 (loop while Z = 1) and 3 (loop while Z = 0) assert `outCountWr` with `outCount` = `countIn` - 1 modulo 2^32, whether or not the loop branches.
- R10: A plain loop is taken exactly when the decremented count is nonzero. A count of 1 falls through, and a count of 0 wraps to 0xFFFFFFFF and is taken.
- R11: Kind 2 is taken when the decremented count is nonzero and Z = 1. Kind 3 is taken when the decremented count is nonzero and Z = 0.
- R12: A conditional branch (kind 0) or an idle cycle leaves `outCountWr` low and `outCount` holding its previous value.
- R13: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqKind | input | 2 | 0 conditional, 1 loop, 2 loop while zero, 3 loop while not zero |
| condSel | input | 4 | Condition code for kind 0 |
| flagS | input | 1 | Sign flag |
| flagZ | input | 1 | Zero flag |
| flagO | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| nextAddr | input | 32 | Address of the instruction after the branch |
| offset | input | 8 | Signed branch displacement |
| countIn | input | 32 | Current loop count |
| outValid | output | 1 | Registered result is valid |
| outTaken | output | 1 | Branch taken |
| outNextPtr | output | 32 | Next instruction pointer |
| outCountWr | output | 1 | Write `outCount` back to the count register |
| outCount | output | 32 | Decremented loop count |

## Verification
The conditional family is swept over all sixteen condition codes against all sixteen flag combinations. This separates each code from its negation and separates the unsigned equations from the signed ones, for example a case with carry set and sign clear. Loop kinds are driven with counts of 0, 1, 2 and a large value, each with Z both set and clear. These cases separate "new count nonzero" from "old count nonzero" and show which variants look at Z. Displacements at +127, -128 and -7, next to addresses near both ends of the address space, exercise sign extension and wraparound. Idle gaps and pseudo-random traffic then check that the held pointer and count values survive between requests.

// File: rtl/brPkg.sv
package brPkg;
  typedef enum logic [1:0] {
    KIND_COND    = 2'd0,
    KIND_LOOP    = 2'd1,
    KIND_LOOP_EQ = 2'd2,
    KIND_LOOP_NE = 2'd3
  } brKind_e;

  typedef struct packed {
    logic valid;
    logic take;
    logic cntWrite;
  } brStrobe_t;
endpackage

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [1:0] reqKind,
  input  logic [3:0] condSel,
  input  logic      flagS,
  input  logic      flagZ,
  input  logic      flagO,
  input  logic      flagC,
  input  logic      cntNonZero,
  output brStrobe_t strobe
);
  localparam int N_PAIRS = 8;

  brKind_e kind;
  logic [N_PAIRS-1:0] pairBase;
  logic [N_PAIRS-1:0] pairUsed;
  logic condHit;
  logic loopHit;
  logic signMismatch;

  assign kind = brKind_e'(reqKind);
  assign signMismatch = flagS ^ flagO;

  // Each even/odd code pair shares one base equation; the low bit inverts it.
  always_comb begin
    pairBase = '0;
    pairUsed = '1;
    pairBase[0] = flagO;
    pairBase[1] = flagC;
    pairBase[2] = flagZ;
    pairBase[3] = flagC | flagZ;
    pairBase[4] = flagS;
    pairUsed[5] = 1'b0;
    pairBase[6] = signMismatch;
    pairBase[7] = flagZ | signMismatch;
  end

  assign condHit = pairUsed[condSel[3:1]] & (pairBase[condSel[3:1]] ^ condSel[0]);

  always_comb begin
    unique case (kind)
      KIND_LOOP:    loopHit = cntNonZero;
      KIND_LOOP_EQ: loopHit = cntNonZero & flagZ;
      KIND_LOOP_NE: loopHit = cntNonZero & ~flagZ;
      default:      loopHit = 1'b0;
    endcase
  end

  always_comb begin
    strobe.valid    = reqValid;
    strobe.take     = reqValid & ((kind == KIND_COND) ? condHit : loopHit);
    strobe.cntWrite = reqValid & (kind != KIND_COND);
  end

  // R6
  unused_never_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0 && condSel[3:1] == 3'b101) |-> !strobe.take);

  // R12
  cond_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqKind == 2'd0) |-> !strobe.cntWrite);

  // R11
  loop_eq_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2 && !flagZ) |-> !strobe.take);
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobe,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [OFS_W-1:0]  offset,
  input  logic [CNT_W-1:0]  countIn,
  output logic              cntNonZero,
  output logic              outValid,
  output logic              outTaken,
  output logic [ADDR_W-1:0] outNextPtr,
  output logic              outCountWr,
  output logic [CNT_W-1:0]  outCount
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] target;
  logic [CNT_W-1:0]  decCount;

  assign offsetExt  = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign target     = nextAddr + offsetExt;
  assign decCount   = countIn - CNT_W'(1);
  assign cntNonZero = |decCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outTaken   <= 1'b0;
      outNextPtr <= '0;
      outCountWr <= 1'b0;
      outCount   <= '0;
    end else begin
      outValid   <= strobe.valid;
      outTaken   <= strobe.take;
      outCountWr <= strobe.cntWrite;
      if (strobe.valid)
        outNextPtr <= strobe.take ? target : nextAddr;
      if (strobe.cntWrite)
        outCount <= decCount;
    end
  end

  // R8
  fallthrough_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.valid && !strobe.take) |=> (outNextPtr == $past(nextAddr)));

  // R9
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWrite |=> (outCount == $past(countIn) - CNT_W'(1)));

  // R10
  taken_loop_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outTaken && outCountWr) |-> (outCount != '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.valid |=> (!outValid && !outTaken && !outCountWr));

  // R12
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntWrite |=> $stable(outCount));
endmodule

// File: rtl/brResolver.sv
module brResolver
  import brPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [3:0]        condSel,
  input  logic              flagS,
  input  logic              flagZ,
  input  logic              flagO,
  input  logic              flagC,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [OFS_W-1:0]  offset,
  input  logic [CNT_W-1:0]  countIn,
  output logic              outValid,
  output logic              outTaken,
  output logic [ADDR_W-1:0] outNextPtr,
  output logic              outCountWr,
  output logic [CNT_W-1:0]  outCount
);
  brStrobe_t strobe;
  logic      cntNonZero;

  brControl i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .condSel(condSel), .flagS(flagS), .flagZ(flagZ), .flagO(flagO),
    .flagC(flagC), .cntNonZero(cntNonZero), .strobe(strobe)
  );

  brDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextAddr(nextAddr),
    .offset(offset), .countIn(countIn), .cntNonZero(cntNonZero),
    .outValid(outValid), .outTaken(outTaken), .outNextPtr(outNextPtr),
    .outCountWr(outCountWr), .outCount(outCount)
  );
endmodule

// File: tb/test_brResolver.sv
module test_brResolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [3:0]  condSel = '0;
  logic        flagS = 1'b0, flagZ = 1'b0, flagO = 1'b0, flagC = 1'b0;
  logic [31:0] nextAddr = '0;
  logic [7:0]  offset = '0;
  logic [31:0] countIn = '0;
  logic        outValid, outTaken, outCountWr;
  logic [31:0] outNextPtr, outCount;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  logic        expValid = 0, expTaken = 0, expWr = 0;
  logic [31:0] expPtr = 0, expCount = 0;
  string tagValid = "R13", tagTake = "R13", tagPtr = "R13", tagCnt = "R13";

  always #10 clk = ~clk;

  brResolver i_brResolver (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .condSel(condSel), .flagS(flagS), .flagZ(flagZ), .flagO(flagO),
    .flagC(flagC), .nextAddr(nextAddr), .offset(offset), .countIn(countIn),
    .outValid(outValid), .outTaken(outTaken), .outNextPtr(outNextPtr),
    .outCountWr(outCountWr), .outCount(outCount)
  );

  task automatic checkOne(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkOne(tagValid, "outValid", 32'(outValid), 32'(expValid));
    checkOne(tagTake, "outTaken", 32'(outTaken), 32'(expTaken));
    checkOne(tagPtr, "outNextPtr", outNextPtr, expPtr);
    checkOne(tagValid == "R13" ? "R13" : tagCnt, "outCountWr", 32'(outCountWr), 32'(expWr));
    checkOne(tagCnt, "outCount", outCount, expCount);
  endtask

  function automatic bit condModel(int code, bit s, bit z, bit o, bit c);
    bit less;
    less = (s != o);
    case (code)
      0: return o;
      1: return !o;
      2: return c;
      3: return !c;
      4: return z;
      5: return !z;
      6: return c || z;
      7: return !c && !z;
      8: return s;
      9: return !s;
      12: return less;
      13: return !less;
      14: return z || less;
      15: return !z && !less;
      default: return 0;
    endcase
  endfunction

  function automatic string condTag(int code);
    if (code == 6 || code == 7) return "R3";
    if (code == 12 || code == 13) return "R4";
    if (code == 14 || code == 15) return "R5";
    if (code == 10 || code == 11) return "R6";
    return "R2";
  endfunction

  task automatic step(input bit v, input int kind, input int code, input bit s,
                      input bit z, input bit o, input bit c, input logic [31:0] na,
                      input logic [7:0] ofs, input logic [31:0] cnt);
    logic [31:0] newCount;
    bit take;
    @(negedge clk);
    compareAll();
    reqValid = v; reqKind = 2'(kind); condSel = 4'(code);
    flagS = s; flagZ = z; flagO = o; flagC = c;
    nextAddr = na; offset = ofs; countIn = cnt;
    tagValid = "R1";
    if (!v) begin
      expValid = 0; expTaken = 0; expWr = 0;
      tagTake = "R1"; tagPtr = "R1"; tagCnt = "R12";
    end else begin
      expValid = 1;
      newCount = cnt - 32'd1;
      if (kind == 0) begin
        take = condModel(code, s, z, o, c);
        tagTake = condTag(code);
        expWr = 0;
        tagCnt = "R12";
      end else begin
        if (kind == 1) take = (newCount != 0);
        else if (kind == 2) take = (newCount != 0) && z;
        else take = (newCount != 0) && !z;
        tagTake = (kind == 1) ? "R10" : "R11";
        expWr = 1;
        expCount = newCount;
        tagCnt = "R9";
      end
      expTaken = take;
      if (take) begin
        expPtr = na + {{24{ofs[7]}}, ofs};
        tagPtr = "R7";
      end else begin
        expPtr = na;
        tagPtr = "R8";
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    compareAll();
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2..R6: every condition code against every flag combination
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        step(1, 0, code, f[3], f[2], f[1], f[0],
             32'h0000_1000 + 32'(code * 64 + f), 8'(f * 17 + code), 32'h55);
      end
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R7: sign extension and wraparound
    step(1, 0, 4, 0, 1, 0, 0, 32'h0000_0107, 8'hF9, 0);
    step(1, 0, 4, 0, 1, 0, 0, 32'hFFFF_FFF0, 8'h7F, 0);
    step(1, 0, 4, 0, 1, 0, 0, 32'h0000_0005, 8'h80, 0);
    step(1, 0, 5, 0, 0, 0, 0, 32'h8000_0000, 8'h80, 0);

    // R9, R10, R11: loop kinds around count boundaries
    for (int kind = 1; kind < 4; kind++) begin
      for (int zf = 0; zf < 2; zf++) begin
        step(1, kind, 0, 0, 1'(zf), 0, 0, 32'h0000_2000, 8'hF9, 32'd1);
        step(1, kind, 0, 0, 1'(zf), 0, 0, 32'h0000_2000, 8'hF9, 32'd0);
        step(1, kind, 0, 0, 1'(zf), 0, 0, 32'h0000_2000, 8'hF9, 32'd2);
        step(1, kind, 0, 0, 1'(zf), 0, 0, 32'h0000_2000, 8'h10, 32'h8000_0000);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end

    // R12: conditional branch after a loop keeps the count
    step(1, 1, 0, 0, 0, 0, 0, 32'h300, 8'h04, 32'd9);
    step(1, 0, 7, 0, 0, 0, 0, 32'h400, 8'h04, 32'd77);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 32'd55);

    // Mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], r[7:4], r[8], r[9], r[10], r[11],
           $urandom, 8'($urandom), (r[12] ? 32'(r[14:13]) : $urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule